// File: doc/BRIEF.md
# IRIG-B DC-Level Time Code Generator

This block turns a host-supplied time-of-year snapshot into a pulse-width-coded, DC-level IRIG-B time code. The code runs at 100 bits per second on a single TTL-level output. A one-pulse-per-second strobe starts each frame. On the strobe's rising edge the block captures the snapshot. The snapshot holds BCD seconds, minutes, hours, day of year and two-digit year, plus leap-second and daylight-saving flags, a signed time-zone offset, a time figure of merit and the straight-binary seconds of the day. The block then sends one 100-slot frame, with every slot timed from the system clock.

Every slot starts high and then drops low. The length of the high part gives the symbol: 2 ms for a binary zero, 5 ms for a binary one and 8 ms for a position marker. The control segment carries the year, the flags, the zone offset and the figure of merit. It ends with an even-parity bit that is built serially while the frame is being sent. After the last slot the output stays low until the next strobe. A strobe that arrives in the middle of a frame resynchronises the output at once.

Top module: `irig_dcls_gen`

## Requirements
- R1: From reset, and until the first strobe rising edge, `tc_out` is low.
- R2: On the clock edge that first samples `pps` high after it was low, a new frame begins. `tc_out` is high in the cycle after that edge. Each of the 100 slots lasts 10*TICKS_PER_MS cycles, and slot 0 begins with that cycle.
- R3: Every slot begins high and drops low after 2 ms for a zero, 5 ms for a one and 8 ms for a marker, then stays low to the end of the slot.
- R4: Slot 0 and every slot whose index ends in 9 (9, 19, ... 99) is a marker.
- R5: All multi-bit fields are sent least significant bit first. Seconds units are in slots 1-4 and tens in 6-8. Minutes units are in 10-13 and tens in 15-17. Hours units are in 20-23 and tens in 25-26. Day units are in 30-33, tens in 35-38 and hundreds in 40-41. Slots 5, 14, 18, 24, 27, 28, 34 and 42-48 are zero.
- R6: Year units are in slots 50-53 and year tens in 55-58. Slot 54 is zero.
- R7: Slot 60 is leap pending, slot 61 is leap direction (1 = delete), slot 62 is daylight pending and slot 63 is daylight active. Slot 64 is the offset sign (1 = minus), slots 65-68 are the offset hours in binary and slot 70 is the half-hour bit.
- R8: Slots 71-74 carry the 4-bit figure of merit.
- R9: Slot 75 is a one exactly when the number of ones in slots 1-74 is odd, so that slots 1-75 together hold an even count of ones.
- R10: Straight-binary seconds bits 0-8 are in slots 80-88 and bits 9-16 are in slots 90-97. Slots 76-78 and 98 are zero.
- R11: Snapshot inputs are captured only on the strobe edge. Changing them during a frame has no effect on that frame.
- R12: After slot 99 the output stays low until the next strobe. A strobe edge during a frame restarts slot 0 at once, using a fresh snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps | input | 1 | One-pulse-per-second strobe, rising edge starts a frame |
| sec_bcd | input | 7 | Seconds, BCD |
| min_bcd | input | 7 | Minutes, BCD |
| hour_bcd | input | 6 | Hours, BCD |
| day_bcd | input | 10 | Day of year, BCD |
| year_bcd | input | 8 | Two-digit year, BCD |
| leap_pend | input | 1 | Leap second pending |
| leap_del | input | 1 | Leap direction, 1 = delete |
| dst_pend | input | 1 | Daylight change pending |
| dst_on | input | 1 | Daylight time active |
| tz_neg | input | 1 | Offset sign, 1 = minus |
| tz_hours | input | 4 | Offset hours, binary |
| tz_half | input | 1 | Extra half hour of offset |
| tfom | input | 4 | Time figure of merit |
| sbs | input | 17 | Straight-binary seconds of day |
| tc_out | output | 1 | DC-level time code |

## Verification
The strobe is captured on the first edge that samples it high, and `tc_out` is decoded from the counter registers, so the first slot's high level appears one cycle after that edge. Slot k then occupies cycles 10*TICKS_PER_MS*k to 10*TICKS_PER_MS*(k+1)-1 counted from that cycle. The bench drives inputs on falling edges and samples `tc_out` on each later falling edge. Each sample is compared with the expected level at its offset within the slot, and one check per slot compares the number of high cycles with the required width. The end of a frame is checked on the sample right after cycle 1999, and a restart is checked on the first sample after a mid-frame strobe.

// File: rtl/irig_pkg.sv
package irig_pkg;

  localparam int FRAME_SLOTS = 100;
  localparam int SLOT_MS     = 10;
  localparam int HI_MS_ZERO  = 2;
  localparam int HI_MS_ONE   = 5;
  localparam int HI_MS_MARK  = 8;
  localparam int IDX_W       = $clog2(FRAME_SLOTS);
  localparam int MS_W        = $clog2(SLOT_MS);
  localparam int PAR_FIRST   = 1;
  localparam int PAR_LAST    = 74;
  localparam int PAR_SLOT    = 75;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_MARK = 2'd2
  } sym_t;

  typedef struct packed {
    logic [6:0]  sec;
    logic [6:0]  min;
    logic [5:0]  hour;
    logic [9:0]  day;
    logic [7:0]  year;
    logic        leap_pend;
    logic        leap_del;
    logic        dst_pend;
    logic        dst_on;
    logic        tz_neg;
    logic [3:0]  tz_hours;
    logic        tz_half;
    logic [3:0]  tfom;
    logic [16:0] sbs;
  } tod_snap_t;

  function automatic logic slot_is_marker(input logic [IDX_W-1:0] idx);
    return (idx == '0) || ((idx % IDX_W'(10)) == IDX_W'(9));
  endfunction

  function automatic logic [MS_W-1:0] sym_high_ms(input sym_t s);
    case (s)
      SYM_MARK: return MS_W'(HI_MS_MARK);
      SYM_ONE:  return MS_W'(HI_MS_ONE);
      default:  return MS_W'(HI_MS_ZERO);
    endcase
  endfunction

endpackage

// File: rtl/irig_slot_timer.sv
module irig_slot_timer
  import irig_pkg::*;
#(
  parameter int TICKS_PER_MS = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             run,
  output logic [MS_W-1:0]  ms_cnt,
  output logic [IDX_W-1:0] slot_idx,
  output logic             slot_end
);

  localparam int TICK_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_MS - 1);
  localparam logic [MS_W-1:0]   MS_LAST   = MS_W'(SLOT_MS - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(FRAME_SLOTS - 1);

  logic [TICK_W-1:0] tick_q, tick_d;
  logic [MS_W-1:0]   ms_q, ms_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              run_q, run_d;
  logic              ms_wrap;

  assign ms_wrap  = run_q && (tick_q == TICK_LAST);
  assign slot_end = ms_wrap && (ms_q == MS_LAST);

  always_comb begin
    tick_d = tick_q;
    ms_d   = ms_q;
    idx_d  = idx_q;
    run_d  = run_q;
    if (start) begin
      tick_d = '0;
      ms_d   = '0;
      idx_d  = '0;
      run_d  = 1'b1;
    end else if (run_q) begin
      if (ms_wrap) begin
        tick_d = '0;
        if (ms_q == MS_LAST) begin
          ms_d = '0;
          if (idx_q == IDX_LAST) begin
            idx_d = '0;
            run_d = 1'b0;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end else begin
          ms_d = ms_q + MS_W'(1);
        end
      end else begin
        tick_d = tick_q + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      ms_q   <= '0;
      idx_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      ms_q   <= ms_d;
      idx_q  <= idx_d;
      run_q  <= run_d;
    end
  end

  assign run      = run_q;
  assign ms_cnt   = ms_q;
  assign slot_idx = idx_q;

  // R2
  slot_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_q <= MS_LAST) && (idx_q <= IDX_LAST));

  // R12
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && idx_q == '0 && ms_q == '0));

  // R12
  frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && idx_q == IDX_LAST && !start) |=> !run_q);

endmodule

// File: rtl/irig_frame_map.sv
module irig_frame_map
  import irig_pkg::*;
(
  input  tod_snap_t              snap,
  output logic [FRAME_SLOTS-1:0] data_bits
);

  always_comb begin
    data_bits        = '0;
    data_bits[4:1]   = snap.sec[3:0];
    data_bits[8:6]   = snap.sec[6:4];
    data_bits[13:10] = snap.min[3:0];
    data_bits[17:15] = snap.min[6:4];
    data_bits[23:20] = snap.hour[3:0];
    data_bits[26:25] = snap.hour[5:4];
    data_bits[33:30] = snap.day[3:0];
    data_bits[38:35] = snap.day[7:4];
    data_bits[41:40] = snap.day[9:8];
    data_bits[53:50] = snap.year[3:0];
    data_bits[58:55] = snap.year[7:4];
    data_bits[60]    = snap.leap_pend;
    data_bits[61]    = snap.leap_del;
    data_bits[62]    = snap.dst_pend;
    data_bits[63]    = snap.dst_on;
    data_bits[64]    = snap.tz_neg;
    data_bits[68:65] = snap.tz_hours;
    data_bits[70]    = snap.tz_half;
    data_bits[74:71] = snap.tfom;
    data_bits[88:80] = snap.sbs[8:0];
    data_bits[97:90] = snap.sbs[16:9];
  end

endmodule

// File: rtl/irig_pulse_shaper.sv
module irig_pulse_shaper
  import irig_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   run,
  input  logic [MS_W-1:0]        ms_cnt,
  input  logic [IDX_W-1:0]       slot_idx,
  input  logic                   slot_end,
  input  logic [FRAME_SLOTS-1:0] data_bits,
  output logic                   tc_out
);

  logic par_q, par_d;
  logic cur_bit;
  logic in_par_span;
  sym_t cur_sym;

  assign in_par_span = (slot_idx >= IDX_W'(PAR_FIRST)) && (slot_idx <= IDX_W'(PAR_LAST));
  assign cur_bit     = (slot_idx == IDX_W'(PAR_SLOT)) ? par_q : data_bits[slot_idx];

  always_comb begin
    if (slot_is_marker(slot_idx)) cur_sym = SYM_MARK;
    else if (cur_bit)             cur_sym = SYM_ONE;
    else                          cur_sym = SYM_ZERO;
  end

  always_comb begin
    par_d = par_q;
    if (start)                          par_d = 1'b0;
    else if (slot_end && in_par_span)   par_d = par_q ^ cur_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= 1'b0;
    else        par_q <= par_d;
  end

  assign tc_out = run && (ms_cnt < sym_high_ms(cur_sym));

  // R9
  par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && slot_idx > IDX_W'(PAR_LAST)) |=> $stable(par_q));

endmodule

// File: rtl/irig_dcls_gen.sv
module irig_dcls_gen
  import irig_pkg::*;
#(
  parameter int TICKS_PER_MS = 100000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pps,
  input  logic [6:0]  sec_bcd,
  input  logic [6:0]  min_bcd,
  input  logic [5:0]  hour_bcd,
  input  logic [9:0]  day_bcd,
  input  logic [7:0]  year_bcd,
  input  logic        leap_pend,
  input  logic        leap_del,
  input  logic        dst_pend,
  input  logic        dst_on,
  input  logic        tz_neg,
  input  logic [3:0]  tz_hours,
  input  logic        tz_half,
  input  logic [3:0]  tfom,
  input  logic [16:0] sbs,
  output logic        tc_out
);

  logic                   pps_q;
  logic                   start;
  tod_snap_t              snap_q, snap_d, snap_in;
  logic                   run;
  logic [MS_W-1:0]        ms_cnt;
  logic [IDX_W-1:0]       slot_idx;
  logic                   slot_end;
  logic [FRAME_SLOTS-1:0] data_bits;

  assign start = pps && !pps_q;

  always_comb begin
    snap_in.sec       = sec_bcd;
    snap_in.min       = min_bcd;
    snap_in.hour      = hour_bcd;
    snap_in.day       = day_bcd;
    snap_in.year      = year_bcd;
    snap_in.leap_pend = leap_pend;
    snap_in.leap_del  = leap_del;
    snap_in.dst_pend  = dst_pend;
    snap_in.dst_on    = dst_on;
    snap_in.tz_neg    = tz_neg;
    snap_in.tz_hours  = tz_hours;
    snap_in.tz_half   = tz_half;
    snap_in.tfom      = tfom;
    snap_in.sbs       = sbs;
  end

  always_comb begin
    snap_d = snap_q;
    if (start) snap_d = snap_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pps_q  <= 1'b0;
      snap_q <= '0;
    end else begin
      pps_q  <= pps;
      snap_q <= snap_d;
    end
  end

  irig_slot_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .run      (run),
    .ms_cnt   (ms_cnt),
    .slot_idx (slot_idx),
    .slot_end (slot_end)
  );

  irig_frame_map u_map (
    .snap      (snap_q),
    .data_bits (data_bits)
  );

  irig_pulse_shaper u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .run       (run),
    .ms_cnt    (ms_cnt),
    .slot_idx  (slot_idx),
    .slot_end  (slot_end),
    .data_bits (data_bits),
    .tc_out    (tc_out)
  );

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tc_out);

  // R3
  fall_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $fell(tc_out)) |-> (ms_cnt == MS_W'(HI_MS_ZERO) ||
                                ms_cnt == MS_W'(HI_MS_ONE)  ||
                                ms_cnt == MS_W'(HI_MS_MARK)));

  // R11
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(snap_q));

endmodule

// File: tb/irig_dcls_gen_test.sv
`timescale 1ns/1ps
module irig_dcls_gen_test;

  localparam int TPM      = 2;
  localparam int SLOT_CYC = 10 * TPM;
  localparam int FRAME_CYC = 100 * SLOT_CYC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pps;
  logic [6:0]  sec_bcd, min_bcd;
  logic [5:0]  hour_bcd;
  logic [9:0]  day_bcd;
  logic [7:0]  year_bcd;
  logic        leap_pend, leap_del, dst_pend, dst_on, tz_neg, tz_half;
  logic [3:0]  tz_hours, tfom;
  logic [16:0] sbs;
  logic        tc_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  int exp_ms [100];

  always #2.5 clk = ~clk;

  irig_dcls_gen #(.TICKS_PER_MS(TPM)) uut (
    .clk(clk), .rst_n(rst_n), .pps(pps),
    .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd),
    .day_bcd(day_bcd), .year_bcd(year_bcd),
    .leap_pend(leap_pend), .leap_del(leap_del),
    .dst_pend(dst_pend), .dst_on(dst_on),
    .tz_neg(tz_neg), .tz_hours(tz_hours), .tz_half(tz_half),
    .tfom(tfom), .sbs(sbs), .tc_out(tc_out)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic string req_of(input int i);
    if (i == 0 || i % 10 == 9) return "R4";
    if (i < 50)  return "R5";
    if (i < 60)  return "R6";
    if (i < 71)  return "R7";
    if (i < 75)  return "R8";
    if (i == 75) return "R9";
    return "R10";
  endfunction

  task automatic load_pattern(input int k);
    case (k)
      0: begin
        sec_bcd = 7'h59; min_bcd = 7'h07; hour_bcd = 6'h23; day_bcd = 10'h365;
        year_bcd = 8'h24; leap_pend = 1; leap_del = 0; dst_pend = 0; dst_on = 1;
        tz_neg = 1; tz_hours = 4'd5; tz_half = 0; tfom = 4'h0; sbs = 17'd86399;
      end
      1: begin
        sec_bcd = 7'h00; min_bcd = 7'h00; hour_bcd = 6'h00; day_bcd = 10'h001;
        year_bcd = 8'h99; leap_pend = 1; leap_del = 1; dst_pend = 1; dst_on = 1;
        tz_neg = 0; tz_hours = 4'd12; tz_half = 1; tfom = 4'hF; sbs = 17'd0;
      end
      2: begin
        sec_bcd = 7'h31; min_bcd = 7'h45; hour_bcd = 6'h12; day_bcd = 10'h200;
        year_bcd = 8'h00; leap_pend = 0; leap_del = 0; dst_pend = 0; dst_on = 0;
        tz_neg = 0; tz_hours = 4'd0; tz_half = 0; tfom = 4'h6; sbs = 17'h1AAAA;
      end
      default: begin
        sec_bcd = '1; min_bcd = '1; hour_bcd = '1; day_bcd = '1; year_bcd = '1;
        leap_pend = 1; leap_del = 1; dst_pend = 1; dst_on = 1; tz_neg = 1;
        tz_hours = '1; tz_half = 1; tfom = '1; sbs = '1;
      end
    endcase
  endtask

  task automatic put(input int pos, input logic v);
    if (v) exp_ms[pos] = 5;
  endtask

  task automatic build_expected();
    int ones;
    for (int i = 0; i < 100; i++) exp_ms[i] = (i == 0 || i % 10 == 9) ? 8 : 2;
    for (int b = 0; b < 4; b++) begin
      put(1 + b, sec_bcd[b]);  put(10 + b, min_bcd[b]); put(20 + b, hour_bcd[b]);
      put(30 + b, day_bcd[b]); put(35 + b, day_bcd[4 + b]);
      put(50 + b, year_bcd[b]); put(55 + b, year_bcd[4 + b]);
      put(65 + b, tz_hours[b]); put(71 + b, tfom[b]);
    end
    for (int b = 0; b < 3; b++) begin
      put(6 + b, sec_bcd[4 + b]); put(15 + b, min_bcd[4 + b]);
    end
    for (int b = 0; b < 2; b++) begin
      put(25 + b, hour_bcd[4 + b]); put(40 + b, day_bcd[8 + b]);
    end
    put(60, leap_pend); put(61, leap_del); put(62, dst_pend); put(63, dst_on);
    put(64, tz_neg); put(70, tz_half);
    for (int b = 0; b < 9; b++) put(80 + b, sbs[b]);
    for (int b = 0; b < 8; b++) put(90 + b, sbs[9 + b]);
    ones = 0;
    for (int i = 1; i <= 74; i++) if (exp_ms[i] == 5) ones++;
    put(75, ones[0]);
  endtask

  // Strobe a frame with pattern k, then sample n_samp cycles.
  // Inputs switch to a junk pattern at sample chg_at (R11).
  task automatic run_frame(input int k, input int n_samp, input int chg_at,
                           input string start_req);
    int hi_cnt;
    int shape_err;
    load_pattern(k);
    build_expected();
    @(negedge clk) pps = 1'b1;
    @(negedge clk) pps = 1'b0;
    check(start_req, int'(tc_out), 1);
    hi_cnt = 0;
    shape_err = 0;
    for (int i = 0; i < n_samp; i++) begin
      int slot, off;
      slot = i / SLOT_CYC;
      off  = i % SLOT_CYC;
      if (i == chg_at) load_pattern(3);
      if (tc_out) hi_cnt++;
      if (int'(tc_out) != int'(off < exp_ms[slot] * TPM)) shape_err++;
      if (off == SLOT_CYC - 1) begin
        check({"R3 ", req_of(slot), (chg_at >= 0) ? " R11" : ""},
              hi_cnt + shape_err * 1000, exp_ms[slot] * TPM);
        hi_cnt = 0;
        shape_err = 0;
      end
      if (i < n_samp - 1) @(negedge clk);
    end
  endtask

  initial begin
    bit fell_low;
    rst_n = 1'b0;
    pps = 1'b0;
    load_pattern(2);
    repeat (4) @(negedge clk);
    check("R1 in reset", int'(tc_out), 0);
    rst_n = 1'b1;
    fell_low = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tc_out) fell_low = 1'b1;
    end
    check("R1 idle before strobe", int'(fell_low), 0);

    run_frame(0, FRAME_CYC, 100, "R2");
    run_frame(1, 700, -1, "R2");
    run_frame(2, FRAME_CYC, -1, "R12 restart");
    // frame has ended; output stays low with pps low
    fell_low = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (tc_out) fell_low = 1'b1;
    end
    check("R12 low after frame", int'(fell_low), 0);
    run_frame(1, FRAME_CYC, -1, "R2");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule